// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Promotable Maskable Source

This block decides, every clock, which interrupt a small CPU core should take next and which 16-bit vector address it should fetch. It collects three non-maskable sources: an illegal-opcode trap, a software interrupt and an external high-priority request. It also collects a set of maskable sources: one external level-sensitive request line plus `NPER` peripheral sources, each of which has a flag and an enable. It applies the core's global maskable-block bit and its separate block bit for the external non-maskable request.

Non-maskable sources always win over maskable ones. The maskable sources follow a fixed ranking by vector address. Software can lift any one of them to the head of that ranking at run time by writing the low byte of its vector into a priority-select register. The pending flag and the vector are registered, so the core reads them one clock after the inputs settle. It samples them at instruction boundaries.

Top module: `intc_prio_top`

## Requirements
- R1: Non-maskable sources outrank every maskable source whatever the global mask. Among themselves the order is fixed: trap (vector 0xFFF8), then software interrupt (0xFFF6), then external non-maskable request (0xFFF4).
- R2: `x_mask`=1 blocks only the external non-maskable request. The trap and the software interrupt still request, and the maskable sources are judged as if that request were absent.
- R3: `i_mask`=1 blocks every maskable source.
- R4: Peripheral k requests only when both `per_flag[k]` and `per_en[k]` are 1.
- R5: The external maskable line is level-sensitive. `irq_act_high`=1 makes a high level active, and `irq_act_high`=0 makes a low level active.
- R6: Maskable vectors are 0xFFF2 for the external line and 0xFFF0-2k for peripheral k. By default, a higher vector address means a higher priority.
- R7: A write of byte B to the priority-select register promotes the maskable source whose vector low byte matches B[7:1]. Bit 0 of B is ignored. The promoted source beats every other maskable source while it requests.
- R8: A written byte that matches no maskable vector, including one that matches a non-maskable vector, leaves the default maskable order in force. The non-maskable order never changes.
- R9: Reset clears `irq_pend` and `irq_vec` and loads the priority-select register with 0xF2, which is the default order.
- R10: `irq_pend` and `irq_vec` reflect the inputs of the previous clock edge. `irq_vec` is 0x0000 whenever nothing is pending. A priority-select write takes part in arbitration from the edge after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_mask | input | 1 | Global block for maskable sources |
| x_mask | input | 1 | Block for the external non-maskable request |
| trap_req | input | 1 | Illegal-opcode trap request |
| swi_req | input | 1 | Software interrupt request |
| xirq_req | input | 1 | External non-maskable request |
| irq_pin | input | 1 | External maskable request line |
| irq_act_high | input | 1 | Active level select for `irq_pin` |
| per_flag | input | NPER | Peripheral event flags |
| per_en | input | NPER | Peripheral local enables |
| psel_we | input | 1 | Priority-select register write strobe |
| psel_wdata | input | 8 | Priority-select write byte |
| irq_pend | output | 1 | An interrupt is pending (registered) |
| irq_vec | output | 16 | Vector address of the winner (registered) |

## Verification
A priority-select write and a live arbitration decision can land on the same clock edge. The bench provokes this by writing the byte for peripheral 5 while peripherals 3 and 5 are both requesting. It expects the first sampled result to still show the old order (0xFFEA) and the next one to show the promoted source (0xFFE6). The same collision is judged against a non-maskable arrival: a promoted maskable source requesting alongside the software interrupt must still yield 0xFFF6.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam logic [7:0] VEC_HI  = 8'hFF;
  localparam logic [7:0] TRAP_LO = 8'hF8;
  localparam logic [7:0] SWI_LO  = 8'hF6;
  localparam logic [7:0] XIRQ_LO = 8'hF4;
  localparam logic [7:0] IRQ_LO  = 8'hF2;

  // Maskable index 0 is the external line; index k+1 is peripheral k.
  function automatic logic [7:0] mvec_lo(input int idx);
    return IRQ_LO - 8'(2 * idx);
  endfunction
endpackage

// File: rtl/intc_src_qual.sv
module intc_src_qual #(
  parameter int NPER = 8,
  localparam int NM  = NPER + 1
) (
  input  logic            i_mask,
  input  logic            x_mask,
  input  logic            trap_req,
  input  logic            swi_req,
  input  logic            xirq_req,
  input  logic            irq_pin,
  input  logic            irq_act_high,
  input  logic [NPER-1:0] per_flag,
  input  logic [NPER-1:0] per_en,
  output logic [2:0]      nmi_ok,
  output logic [NM-1:0]   mreq
);
  logic [NM-1:0] raw;

  assign raw[0] = (irq_pin == irq_act_high);

  for (genvar k = 0; k < NPER; k++) begin : g_per
    assign raw[k+1] = per_flag[k] & per_en[k];
  end

  assign mreq   = i_mask ? '0 : raw;
  assign nmi_ok = {trap_req, swi_req, xirq_req & ~x_mask};
endmodule

// File: rtl/intc_psel_reg.sv
module intc_psel_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:1] wbits,
  output logic [7:1] psel_q
);
  import intc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)     psel_q <= IRQ_LO[7:1];
    else if (we) psel_q <= wbits;
  end

  // R7
  psel_load_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (psel_q == $past(wbits)));
endmodule

// File: rtl/intc_mask_arb.sv
module intc_mask_arb #(
  parameter int NM = 9,
  localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic [NM-1:0] mreq,
  input  logic [7:1]    psel,
  output logic          any,
  output logic [7:0]    vec_lo
);
  import intc_pkg::*;

  logic [NM-1:0] hit;
  logic [NM-1:0] grant;
  logic [IW-1:0] fix_idx;
  logic [IW-1:0] prom_idx;
  logic [IW-1:0] win_idx;
  logic          prom_live;

  for (genvar i = 0; i < NM; i++) begin : g_hit
    localparam logic [7:0] LO = mvec_lo(i);
    assign hit[i] = (LO[7:1] == psel);
  end

  always_comb begin
    fix_idx  = '0;
    prom_idx = '0;
    for (int k = NM - 1; k >= 0; k--) begin
      if (mreq[k]) fix_idx = IW'(k);
      if (hit[k])  prom_idx = IW'(k);
    end
  end

  assign prom_live = |(hit & mreq);
  assign any       = |mreq;
  assign win_idx   = prom_live ? prom_idx : fix_idx;
  assign vec_lo    = mvec_lo(int'(win_idx));

  always_comb begin
    grant = '0;
    if (any) grant[win_idx] = 1'b1;
  end

  // R7
  always_comb begin
    grant_onehot_chk: assert ($onehot0(grant));
  end
  // R7
  always_comb begin
    prom_wins_chk: assert (!prom_live || (|(grant & hit)));
  end
endmodule

// File: rtl/intc_prio_top.sv
module intc_prio_top #(
  parameter int NPER = 8,
  localparam int NM  = NPER + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_mask,
  input  logic            x_mask,
  input  logic            trap_req,
  input  logic            swi_req,
  input  logic            xirq_req,
  input  logic            irq_pin,
  input  logic            irq_act_high,
  input  logic [NPER-1:0] per_flag,
  input  logic [NPER-1:0] per_en,
  input  logic            psel_we,
  input  logic [7:0]      psel_wdata,
  output logic            irq_pend,
  output logic [15:0]     irq_vec
);
  import intc_pkg::*;

  logic [2:0]    nmi_ok;
  logic [NM-1:0] mreq;
  logic [7:1]    psel_q;
  logic          m_any;
  logic [7:0]    m_lo;
  logic          nx_pend;
  logic [7:0]    nx_lo;
  logic          psel_unused;

  assign psel_unused = psel_wdata[0];

  intc_src_qual #(.NPER(NPER)) u_qual (
    .i_mask(i_mask), .x_mask(x_mask), .trap_req(trap_req),
    .swi_req(swi_req), .xirq_req(xirq_req), .irq_pin(irq_pin),
    .irq_act_high(irq_act_high), .per_flag(per_flag), .per_en(per_en),
    .nmi_ok(nmi_ok), .mreq(mreq)
  );

  intc_psel_reg u_psel (
    .clk(clk), .rst(rst), .we(psel_we), .wbits(psel_wdata[7:1]),
    .psel_q(psel_q)
  );

  intc_mask_arb #(.NM(NM)) u_arb (
    .mreq(mreq), .psel(psel_q), .any(m_any), .vec_lo(m_lo)
  );

  always_comb begin
    nx_pend = 1'b1;
    if      (nmi_ok[2]) nx_lo = TRAP_LO;
    else if (nmi_ok[1]) nx_lo = SWI_LO;
    else if (nmi_ok[0]) nx_lo = XIRQ_LO;
    else if (m_any)     nx_lo = m_lo;
    else begin
      nx_pend = 1'b0;
      nx_lo   = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend <= 1'b0;
      irq_vec  <= 16'h0000;
    end else begin
      irq_pend <= nx_pend;
      irq_vec  <= nx_pend ? {VEC_HI, nx_lo} : 16'h0000;
    end
  end

  // R1
  nmi_over_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(trap_req)) |-> (irq_pend && irq_vec == {VEC_HI, TRAP_LO}));
  // R3
  gmask_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(i_mask) && !$past(trap_req || swi_req || xirq_req))
      |-> !irq_pend);
  // R10
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_pend |-> (irq_vec == 16'h0000));
  // R6
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pend |-> (irq_vec[15:8] == VEC_HI && !irq_vec[0]));
endmodule

// File: tb/tb_intc_prio_top.sv
module tb_intc_prio_top;
  localparam int NPER = 8;
  localparam int NROW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_mask = 1'b0, x_mask = 1'b0;
  logic trap_req = 1'b0, swi_req = 1'b0, xirq_req = 1'b0;
  logic irq_pin = 1'b0, irq_act_high = 1'b1;
  logic [NPER-1:0] per_flag = '0, per_en = '0;
  logic psel_we = 1'b0;
  logic [7:0] psel_wdata = 8'h00;
  logic irq_pend;
  logic [15:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  intc_prio_top #(.NPER(NPER)) dut (
    .clk(clk), .rst(rst), .i_mask(i_mask), .x_mask(x_mask),
    .trap_req(trap_req), .swi_req(swi_req), .xirq_req(xirq_req),
    .irq_pin(irq_pin), .irq_act_high(irq_act_high),
    .per_flag(per_flag), .per_en(per_en),
    .psel_we(psel_we), .psel_wdata(psel_wdata),
    .irq_pend(irq_pend), .irq_vec(irq_vec)
  );

  // {trap, swi, xirq, x_mask, i_mask, irq_pin, irq_act_high, flags, enables}
  localparam logic [22:0] STIM [NROW] = '{
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00,8'h00}, // R10 idle
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h00,8'h00}, // R5 high active
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,8'h00}, // R5 low active
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h08,8'h08}, // R4 p3 only
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h28,8'h28}, // R6 p3 over p5
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h28,8'h20}, // R4 p3 not enabled
    {1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,8'h20,8'h20}, // R3 global block
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,8'h00,8'h00}, // R1 xirq through i_mask
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,8'h00,8'h00}, // R2 xirq blocked
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,8'h00,8'h00}, // R2 all blocked
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,8'h00,8'h00}, // R2 swi ignores x
    {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h00}, // R1 trap first
    {1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,8'h00,8'h00}, // R1 swi over xirq
    {1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,8'h00,8'h00}, // R1 xirq over irq
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h81,8'h81}, // R6 p0 over p7
    {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h80,8'h80}  // R6 p7 alone
  };
  localparam logic [16:0] EXPV [NROW] = '{
    {1'b0,16'h0000}, {1'b1,16'hFFF2}, {1'b1,16'hFFF2}, {1'b1,16'hFFEA},
    {1'b1,16'hFFEA}, {1'b1,16'hFFE6}, {1'b0,16'h0000}, {1'b1,16'hFFF4},
    {1'b1,16'hFFF2}, {1'b0,16'h0000}, {1'b1,16'hFFF6}, {1'b1,16'hFFF8},
    {1'b1,16'hFFF6}, {1'b1,16'hFFF4}, {1'b1,16'hFFF0}, {1'b1,16'hFFE2}
  };

  function automatic string row_tag(input int r);
    case (r)
      0: return "R10";
      1, 2: return "R5";
      3, 5: return "R4";
      4, 14, 15: return "R6";
      6: return "R3";
      8, 9, 10: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input logic pend_e, input logic [15:0] vec_e);
    total++;
    if (irq_pend !== pend_e || irq_vec !== vec_e) begin
      bad++;
      $display("FAIL %s: got pend=%0b vec=%h, expected pend=%0b vec=%h",
               req, irq_pend, irq_vec, pend_e, vec_e);
    end
  endtask

  task automatic drive(input logic [22:0] s);
    {trap_req, swi_req, xirq_req, x_mask, i_mask, irq_pin, irq_act_high,
     per_flag, per_en} = s;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_psel(input logic [7:0] b);
    psel_we = 1'b1;
    psel_wdata = b;
    step();
    psel_we = 1'b0;
  endtask

  localparam logic [22:0] P3P5 = {7'b0000001, 8'h28, 8'h28};
  localparam logic [22:0] P3   = {7'b0000001, 8'h08, 8'h08};

  initial begin
    repeat (3) @(negedge clk);
    check("R9", 1'b0, 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    for (int r = 0; r < NROW; r++) begin
      drive(STIM[r]);
      step();
      check(row_tag(r), EXPV[r][16], EXPV[r][15:0]);
    end

    // R7 promote p5 (0xE6), then p3 and p5 together
    drive('0); irq_act_high = 1'b1;
    wr_psel(8'hE6);
    drive(P3P5); step();
    check("R7", 1'b1, 16'hFFE6);
    // R7 promoted source beats the external line
    irq_pin = 1'b1; step();
    check("R7", 1'b1, 16'hFFE6);
    irq_pin = 1'b0;
    // R7 promoted source idle: default order among the rest
    drive(P3); step();
    check("R7", 1'b1, 16'hFFEA);
    // R7 bit 0 ignored
    wr_psel(8'h10);
    wr_psel(8'hE7);
    drive(P3P5); step();
    check("R7", 1'b1, 16'hFFE6);
    // R1 non-maskable still wins over a promoted source
    swi_req = 1'b1; step();
    check("R1", 1'b1, 16'hFFF6);
    swi_req = 1'b0;
    // R8 unmatched byte restores default
    wr_psel(8'h10);
    drive(P3P5); step();
    check("R8", 1'b1, 16'hFFEA);
    // R8 non-maskable vector byte: no maskable change, NMI order kept
    wr_psel(8'hF4);
    step();
    check("R8", 1'b1, 16'hFFEA);
    drive({3'b011, 4'b0000, 16'h0000}); irq_act_high = 1'b1; step();
    check("R8", 1'b1, 16'hFFF6);
    // R10 write and arbitration on the same edge
    drive(P3P5);
    psel_we = 1'b1; psel_wdata = 8'hE6;
    step();
    psel_we = 1'b0;
    check("R10", 1'b1, 16'hFFEA);
    step();
    check("R10", 1'b1, 16'hFFE6);
    // R9 reset restores default order
    rst = 1'b1; step();
    check("R9", 1'b0, 16'h0000);
    rst = 1'b0; step();
    check("R9", 1'b1, 16'hFFEA);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule